// File: doc/BRIEF.md
# Floppy Disk Controller Command Sequencer

This block is the host-side command engine of a floppy disk controller. A host on a byte-wide I/O bus polls a main status byte to learn whether the controller wants a byte, which direction that byte travels and whether a command is in flight. It then moves command and result bytes through a single data port. Each command starts with an opcode byte. The opcode is followed by the number of parameter bytes that it calls for. A short execution phase comes next, and the command ends with a result phase in which the host reads status bytes back.

Six operations are accepted: sense interrupt, absolute seek, relative seek in both directions, read ID, read and verify. The present cylinder is held inside the block and is changed by the seek commands. A neighbouring block supplies a media-present flag, which the read and verify commands use to shape their status bytes. The interrupt line tells the host when a seek has finished and when a read-type command has results waiting.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the block is in the command phase, the status byte reads 0x80 and the interrupt is low.
- R2: Offset 4 reads the status byte. Bit 7 means the data port is ready, bit 6 means the direction is to the host and bit 4 means busy. The byte reads 0x80 in the command phase, 0x90 while parameters are being collected, 0x10 during execution and 0xD0 in the result phase. Offset 5 is the data port. Every other offset reads 0x00.
- R3: Sense interrupt (0x08) takes no parameter bytes. Read ID (0x0A) takes one. Seek (0x0F) and both relative seeks take two. Read (0xE6) and verify (0x16) take eight. The interrupt is low while parameters are being collected.
- R4: Seek sets the present cylinder to its second parameter. It raises the interrupt as soon as that byte is accepted and goes straight back to the command phase without a result phase.
- R5: Relative seek in (0xCF) adds its step count to the present cylinder, and relative seek out (0x8F) subtracts it. Every seek result is limited to the range 0 to MAX_CYL-1.
- R6: Sense interrupt clears the interrupt. If no seek has finished since the last sense, it returns the single byte 0x80. Otherwise it returns 0x20 OR (head<<2) followed by the present cylinder, where head is bit 2 of the seek's first parameter.
- R7: Read ID stays in execution for exactly RID_CYCLES clock cycles. It then returns seven bytes: head<<2, 0, 0, present cylinder, head, 1, 2.
- R8: Read and verify return seven bytes: ST0, ST1, 0, then parameters two to five (cylinder, head, sector, size). With media present, ST0 is head<<2 and ST1 is 0. Without media, ST0 is 0x40 OR (head<<2) and ST1 is 0x05.
- R9: Read ID, read and verify raise the interrupt when the result phase begins. The interrupt stays high until the seventh byte is read, and the block then returns to the command phase with the interrupt low.
- R10: A data-port write in the result or execution phase, and a data-port read in the command or parameter phase, are ignored. An ignored read returns 0x00, and neither access changes the phase or the byte position.
- R11: An opcode outside the supported set takes no parameters and returns the single byte 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| media_present | input | 1 | Media present in the drive |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch every cycle for these rules: the interrupt stays quiet while parameters are collected, the status byte matches the command and execution phases, the interrupt rises right after a seek's last byte, the interrupt falls and the phase returns to command on the last result read, and a data-port write in the result phase is ignored. Only the bench scenarios can show the result byte values: cylinder arithmetic and its limits, sense answers before and after a seek, media-dependent status, the exact length of the read ID execution phase, and the fact that stray accesses leave the result stream unchanged.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  typedef enum logic [1:0] {PH_CMD, PH_PARAM, PH_EXEC, PH_RESULT} fdc_phase_e;

  localparam logic [7:0] OP_SENSE   = 8'h08;
  localparam logic [7:0] OP_READID  = 8'h0A;
  localparam logic [7:0] OP_SEEK    = 8'h0F;
  localparam logic [7:0] OP_VERIFY  = 8'h16;
  localparam logic [7:0] OP_READ    = 8'hE6;
  localparam logic [7:0] OP_RSK_OUT = 8'h8F;
  localparam logic [7:0] OP_RSK_IN  = 8'hCF;

  localparam logic [7:0] MSR_IDLE   = 8'h80;
  localparam logic [7:0] MSR_PARAM  = 8'h90;
  localparam logic [7:0] MSR_EXEC   = 8'h10;
  localparam logic [7:0] MSR_RESULT = 8'hD0;

  function automatic logic is_seek(input logic [7:0] op);
    return (op == OP_SEEK) || (op == OP_RSK_IN) || (op == OP_RSK_OUT);
  endfunction

  function automatic logic [3:0] param_count(input logic [7:0] op);
    case (op)
      OP_READID:                     return 4'd1;
      OP_SEEK, OP_RSK_IN, OP_RSK_OUT: return 4'd2;
      OP_READ, OP_VERIFY:            return 4'd8;
      default:                       return 4'd0;
    endcase
  endfunction

  function automatic logic [2:0] result_count(input logic [7:0] op, input logic hit);
    case (op)
      OP_SENSE:                     return hit ? 3'd2 : 3'd1;
      OP_READID, OP_READ, OP_VERIFY: return 3'd7;
      default:                      return 3'd1;
    endcase
  endfunction

  function automatic logic [7:0] seek_target(input logic [7:0] op, input logic [7:0] cur,
                                             input logic [7:0] arg, input logic [7:0] last);
    logic [8:0] s;
    case (op)
      OP_SEEK:   s = {1'b0, arg};
      OP_RSK_IN: s = {1'b0, cur} + {1'b0, arg};
      OP_RSK_OUT: s = (arg > cur) ? 9'd0 : ({1'b0, cur} - {1'b0, arg});
      default:   s = {1'b0, cur};
    endcase
    if (s > {1'b0, last}) s = {1'b0, last};
    return s[7:0];
  endfunction

endpackage

// File: rtl/fdc_param_store.sv
module fdc_param_store #(
  parameter int NPARAM = 8,
  localparam int IW = $clog2(NPARAM + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IW-1:0]          idx,
  input  logic [7:0]             wdata,
  output logic [NPARAM-1:0][7:0] prm
);
  for (genvar g = 0; g < NPARAM; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) prm[g] <= 8'h00;
      else if (wr_en && (idx == IW'(g))) prm[g] <= wdata;
    end
  end
endmodule

// File: rtl/fdc_exec_timer.sv
module fdc_exec_timer #(
  parameter int MAXV = 20,
  localparam int CW = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          active,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (active && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end
  assign done = active && (cnt_q == CW'(1));
endmodule

// File: rtl/fdc_result_mux.sv
module fdc_result_mux
  import fdc_pkg::*;
#(
  parameter int NPARAM = 8
) (
  input  logic [7:0]             op,
  input  logic                   sense_hit,
  input  logic                   seek_head,
  input  logic                   media,
  input  logic [7:0]             cyl,
  input  logic [NPARAM-1:0][7:0] prm,
  input  logic [2:0]             idx,
  output logic [7:0]             byte_o
);
  logic       hd;
  logic [7:0] st0_rw;
  assign hd     = prm[0][2];
  assign st0_rw = {1'b0, ~media, 3'b000, hd, 2'b00};

  always_comb begin
    byte_o = 8'h80;
    case (op)
      OP_SENSE: if (sense_hit) byte_o = (idx == 3'd0) ? {5'b00100, seek_head, 2'b00} : cyl;
      OP_READID:
        case (idx)
          3'd0: byte_o = {5'b00000, hd, 2'b00};
          3'd3: byte_o = cyl;
          3'd4: byte_o = {7'd0, hd};
          3'd5: byte_o = 8'd1;
          3'd6: byte_o = 8'd2;
          default: byte_o = 8'h00;
        endcase
      OP_READ, OP_VERIFY:
        case (idx)
          3'd0: byte_o = st0_rw;
          3'd1: byte_o = media ? 8'h00 : 8'h05;
          3'd3: byte_o = prm[1];
          3'd4: byte_o = prm[2];
          3'd5: byte_o = prm[3];
          3'd6: byte_o = prm[4];
          default: byte_o = 8'h00;
        endcase
      default: byte_o = 8'h80;
    endcase
  end
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_pkg::*;
#(
  parameter int MAX_CYL    = 80,
  parameter int RID_CYCLES = 20,
  parameter int NPARAM     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       media_present,
  output logic       irq
);
  localparam int IW = $clog2(NPARAM + 1);
  localparam int CW = $clog2(RID_CYCLES + 1);
  localparam logic [7:0] LAST_CYL = 8'(MAX_CYL - 1);

  fdc_phase_e phase_q;
  logic [7:0] op_q, cyl_q;
  logic [IW-1:0] pidx_q;
  logic [2:0] ridx_q;
  logic seek_done_q, seek_head_q, sense_hit_q, media_q, irq_q;
  logic [NPARAM-1:0][7:0] prm;

  logic wr_fifo, rd_fifo, wr_acc, rd_acc, param_wr;
  logic last_param, last_read, seek_fin, exec_load, exec_done;
  logic [3:0] nparam;
  logic [2:0] nres;
  logic [7:0] res_byte, msr;
  logic [CW-1:0] exec_len;

  assign wr_fifo    = bus_wr && (bus_addr == 3'd5);
  assign rd_fifo    = bus_rd && (bus_addr == 3'd5);
  assign wr_acc     = wr_fifo && ((phase_q == PH_CMD) || (phase_q == PH_PARAM));
  assign rd_acc     = rd_fifo && (phase_q == PH_RESULT);
  assign param_wr   = wr_acc && (phase_q == PH_PARAM);
  assign nparam     = param_count(op_q);
  assign last_param = param_wr && (4'(pidx_q) == nparam - 4'd1);
  assign seek_fin   = last_param && is_seek(op_q);
  assign exec_load  = last_param && !is_seek(op_q);
  assign exec_len   = (op_q == OP_READID) ? CW'(RID_CYCLES) : CW'(1);
  assign nres       = result_count(op_q, sense_hit_q);
  assign last_read  = rd_acc && (ridx_q == nres - 3'd1);

  fdc_param_store #(.NPARAM(NPARAM)) i_prm (
    .clk(clk), .rst_n(rst_n), .wr_en(param_wr), .idx(pidx_q),
    .wdata(bus_wdata), .prm(prm)
  );

  fdc_exec_timer #(.MAXV(RID_CYCLES)) i_tmr (
    .clk(clk), .rst_n(rst_n), .load(exec_load), .load_val(exec_len),
    .active(phase_q == PH_EXEC), .done(exec_done)
  );

  fdc_result_mux #(.NPARAM(NPARAM)) i_res (
    .op(op_q), .sense_hit(sense_hit_q), .seek_head(seek_head_q), .media(media_q),
    .cyl(cyl_q), .prm(prm), .idx(ridx_q), .byte_o(res_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;  op_q <= 8'h00;  cyl_q <= 8'h00;
      pidx_q <= '0;       ridx_q <= 3'd0;
      seek_done_q <= 1'b0; seek_head_q <= 1'b0; sense_hit_q <= 1'b0;
      media_q <= 1'b0;    irq_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_CMD: if (wr_acc) begin
          op_q   <= bus_wdata;
          irq_q  <= 1'b0;
          pidx_q <= '0;
          ridx_q <= 3'd0;
          if (param_count(bus_wdata) == 4'd0) begin
            phase_q     <= PH_RESULT;
            sense_hit_q <= (bus_wdata == OP_SENSE) && seek_done_q;
            if (bus_wdata == OP_SENSE) seek_done_q <= 1'b0;
          end else begin
            phase_q <= PH_PARAM;
          end
        end
        PH_PARAM: if (param_wr) begin
          pidx_q <= pidx_q + 1'b1;
          if (seek_fin) begin
            cyl_q       <= seek_target(op_q, cyl_q, bus_wdata, LAST_CYL);
            seek_done_q <= 1'b1;
            seek_head_q <= prm[0][2];
            irq_q       <= 1'b1;
            phase_q     <= PH_CMD;
          end else if (last_param) begin
            phase_q <= PH_EXEC;
          end
        end
        PH_EXEC: if (exec_done) begin
          phase_q <= PH_RESULT;
          ridx_q  <= 3'd0;
          media_q <= media_present;
          irq_q   <= 1'b1;
        end
        PH_RESULT: if (rd_acc) begin
          ridx_q <= ridx_q + 1'b1;
          if (last_read) begin
            phase_q <= PH_CMD;
            irq_q   <= 1'b0;
          end
        end
        default: phase_q <= PH_CMD;
      endcase
    end
  end

  always_comb begin
    case (phase_q)
      PH_CMD:   msr = MSR_IDLE;
      PH_PARAM: msr = MSR_PARAM;
      PH_EXEC:  msr = MSR_EXEC;
      default:  msr = MSR_RESULT;
    endcase
  end

  always_comb begin
    if (bus_addr == 3'd4)                              bus_rdata = msr;
    else if (bus_addr == 3'd5 && phase_q == PH_RESULT) bus_rdata = res_byte;
    else                                               bus_rdata = 8'h00;
  end

  assign irq = irq_q;
endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk
  import fdc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       irq,
  input fdc_phase_e phase_q,
  input logic       seek_fin,
  input logic       last_read
);
  AST_IRQ_QUIET_PARAM: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PARAM) |-> !irq); // R3
  AST_CMD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CMD && bus_addr == 3'd4) |-> (bus_rdata == 8'h80)); // R2
  AST_EXEC_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC && bus_addr == 3'd4) |-> (bus_rdata == 8'h10)); // R2
  AST_SEEK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    seek_fin |=> (irq && phase_q == PH_CMD)); // R4
  AST_LAST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    last_read |=> (!irq && phase_q == PH_CMD)); // R9
  AST_RESULT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RESULT && bus_wr && !bus_rd && bus_addr == 3'd5) |=> (phase_q == PH_RESULT)); // R10
endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .irq(irq), .phase_q(phase_q), .seek_fin(seek_fin),
  .last_read(last_read)
);

// File: tb/test_fdc_cmd_seq.sv
module test_fdc_cmd_seq;
  localparam int CLK_P   = 10;
  localparam int MAXC    = 80;
  localparam int RID_CYC = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, media_present = 1'b1;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 0;
  int exp_q[$];
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  fdc_cmd_seq #(.MAX_CYL(MAXC), .RID_CYCLES(RID_CYC), .NPARAM(8)) i_fdc_cmd_seq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .media_present(media_present), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: compares each data-port read against the scoreboard queue
  always @(negedge clk) begin
    if (bus_rd && bus_addr == 3'd5 && exp_q.size() > 0) begin
      int e;
      e = exp_q.pop_front();
      chk(cur_req, int'(bus_rdata), e);
    end
  end

  task automatic wr_byte(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 3'd4;
  endtask

  task automatic rd_fifo();
    @(posedge clk); #1;
    bus_addr = 3'd5; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_addr = 3'd4;
  endtask

  task automatic get_msr(output logic [7:0] v);
    bus_addr = 3'd4; #1; v = bus_rdata;
  endtask

  task automatic expect_bytes(string req, int b[]);
    cur_req = req;
    foreach (b[k]) exp_q.push_back(b[k]);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) rd_fifo();
  endtask

  task automatic wait_result();
    logic [7:0] m;
    for (int k = 0; k < 200; k++) begin
      get_msr(m);
      if (m == 8'hD0) break;
      @(posedge clk); #1;
    end
  endtask

  function automatic int clamp_cyl(int v);
    if (v < 0) return 0;
    if (v > MAXC - 1) return MAXC - 1;
    return v;
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] m;
    int cyl, n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state, R2 other offset
    get_msr(m); chk("R1 msr", m, 8'h80);
    chk("R1 irq", irq, 0);
    bus_addr = 3'd2; #1; chk("R2 other offset", bus_rdata, 0);

    // R10 ignored read in command phase
    @(posedge clk); #1; bus_addr = 3'd5; bus_rd = 1'b1; #1;
    chk("R10 ignored read data", bus_rdata, 0);
    @(posedge clk); #1; bus_rd = 1'b0;
    get_msr(m); chk("R10 phase kept", m, 8'h80);

    // R6 sense without pending seek
    wr_byte(5, 8'h08);
    get_msr(m); chk("R2 result msr", m, 8'hD0);
    expect_bytes("R6 idle sense", '{8'h80}); drain();
    get_msr(m); chk("R6 back to cmd", m, 8'h80);

    // R4 absolute seek head 1 cylinder 5
    wr_byte(5, 8'h0F);
    get_msr(m); chk("R2 param msr", m, 8'h90);
    wr_byte(5, 8'h04);
    chk("R3 irq low in params", irq, 0);
    wr_byte(5, 8'd5);
    chk("R4 irq after seek", irq, 1);
    get_msr(m); chk("R4 no result phase", m, 8'h80);
    wr_byte(5, 8'h08);
    chk("R6 sense clears irq", irq, 0);
    expect_bytes("R6 sense after seek", '{8'h24, 5}); drain();
    cyl = 5;

    // R5 relative seeks with limits
    wr_byte(5, 8'hCF); wr_byte(5, 8'h00); wr_byte(5, 8'd3);
    cyl = clamp_cyl(cyl + 3);
    wr_byte(5, 8'h08); expect_bytes("R5 step in", '{8'h20, cyl}); drain();
    wr_byte(5, 8'h8F); wr_byte(5, 8'h00); wr_byte(5, 8'd10);
    cyl = clamp_cyl(cyl - 10);
    wr_byte(5, 8'h08); expect_bytes("R5 step out floor", '{8'h20, cyl}); drain();
    wr_byte(5, 8'hCF); wr_byte(5, 8'h00); wr_byte(5, 8'd250);
    cyl = clamp_cyl(cyl + 250);
    wr_byte(5, 8'h08); expect_bytes("R5 step in ceiling", '{8'h20, cyl}); drain();
    wr_byte(5, 8'h0F); wr_byte(5, 8'h00); wr_byte(5, 8'd8);
    cyl = 8;
    wr_byte(5, 8'h08); expect_bytes("R4 seek to 8", '{8'h20, 8}); drain();

    // R7 read ID head 1, exec length
    wr_byte(5, 8'h0A);
    chk("R3 irq low read id param", irq, 0);
    wr_byte(5, 8'h04);
    n = 0;
    get_msr(m);
    while (m == 8'h10 && n < 1000) begin
      n++; @(posedge clk); #1; get_msr(m);
    end
    chk("R7 exec cycles", n, RID_CYC);
    chk("R9 irq at result", irq, 1);
    expect_bytes("R7 read id", '{8'h04, 0, 0, 8, 1, 1, 2});
    repeat (6) rd_fifo();
    chk("R9 irq held before last", irq, 1);
    rd_fifo();
    chk("R9 irq drops after last", irq, 0);
    get_msr(m); chk("R9 cmd after last", m, 8'h80);

    // R10 write during exec ignored
    wr_byte(5, 8'h0A); wr_byte(5, 8'h00);
    wr_byte(5, 8'h08);
    wait_result();
    expect_bytes("R10 exec write ignored", '{8'h00, 0, 0, 8, 0, 1, 2}); drain();

    // R8 read with media
    media_present = 1'b1;
    wr_byte(5, 8'hE6);
    wr_byte(5, 8'h00); wr_byte(5, 8'd3); wr_byte(5, 8'd0); wr_byte(5, 8'd1);
    wr_byte(5, 8'd2); wr_byte(5, 8'd1); wr_byte(5, 8'h1B);
    chk("R3 irq low before last param", irq, 0);
    wr_byte(5, 8'hFF);
    wait_result();
    chk("R9 read irq", irq, 1);
    expect_bytes("R8 read media", '{8'h00, 8'h00, 0, 3, 0, 1, 2}); drain();
    chk("R9 read irq low", irq, 0);

    // R8 verify without media, R10 write in result ignored
    media_present = 1'b0;
    wr_byte(5, 8'h16);
    wr_byte(5, 8'h04); wr_byte(5, 8'd7); wr_byte(5, 8'd1); wr_byte(5, 8'd4);
    wr_byte(5, 8'd2); wr_byte(5, 8'd4); wr_byte(5, 8'h1B); wr_byte(5, 8'hFF);
    wait_result();
    expect_bytes("R8 verify no media", '{8'h44, 8'h05, 0, 7, 1, 4, 2});
    repeat (3) rd_fifo();
    wr_byte(5, 8'h0F);
    get_msr(m); chk("R10 result write ignored", m, 8'hD0);
    drain();
    media_present = 1'b1;

    // R11 unknown opcode
    wr_byte(5, 8'h55);
    expect_bytes("R11 unknown opcode", '{8'h80}); drain();
    get_msr(m); chk("R11 back to cmd", m, 8'h80);

    repeat (3) @(posedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule